// File: doc/BRIEF.md
# Serial Register-Access Slave with Shared-Line Mode

This block is a serial peripheral slave that lets a host read and write a byte-wide register file through an internal address pointer. The host selects the slave with an active-low chip select. It then sends a command byte, followed by one or more data bytes. One command loads the pointer. The other two commands stream writes or reads starting at the pointer, and the pointer advances by one after every data byte.

A static configuration input picks one of two pin arrangements:

- **Full-duplex mode.** The host shifts bits in on MOSI while the slave shifts bits out on MISO at the same time.
- **Shared-line mode.** One data line carries both directions. The host drives it for the command byte. After a read command, the slave takes the line, using a separate output and output enable. The host and the pad logic combine these into the shared wire.

The serial clock, the select and the data inputs are brought into the system clock with two-flop synchronizers. Edges are then detected in the system clock domain, so the system clock must run at least eight times faster than the serial clock.

Top module: `spi_regfile_slave`

## Requirements
- R1: While `cs_n` is high, `miso` and `sio_oe` are 0. Serial clock edges in that time change neither the registers nor the pointer.
- R2: Transfers use clock mode 0. Input bits are sampled on the rising edge of `sck` and output bits change after the falling edge. Bit 7 of each byte moves first.
- R3: Command byte 0x7D followed by one byte loads the pointer with that byte. The slave then accepts a new command byte within the same selection.
- R4: Command byte 0x7E writes each following data byte to the register at the pointer. The pointer increments after each byte.
- R5: Command byte 0x7F sends the register at the pointer in each following byte. The pointer increments after each byte, for as long as the host keeps clocking.
- R6: The pointer wraps from 0xFF to 0x00 during both streaming writes and streaming reads.
- R7: In full-duplex mode, the slave shifts out the register at the current pointer on `miso` during the command byte.
- R8: In shared-line mode, `sio_oe` stays 0 during command and write phases. It rises after the falling edge that ends the eighth bit of a 0x7F command, and it stays 1 until `cs_n` goes high.
- R9: A command byte other than 0x7D, 0x7E or 0x7F makes the slave ignore every further byte until `cs_n` goes high.
- R10: Raising `cs_n` in the middle of a byte discards that byte without a write. The pointer keeps its value and the next selection starts with a fresh command byte.
- R11: In shared-line mode, `miso` stays 0 and data is taken from `sio_in` only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shared | input | 1 | 0: full duplex, 1: shared data line; change only while deselected |
| sck | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host, full-duplex mode |
| miso | output | 1 | Serial data to host, full-duplex mode |
| sio_in | input | 1 | Shared line as received |
| sio_out | output | 1 | Value the slave drives on the shared line |
| sio_oe | output | 1 | Drive enable for the shared line |

## Verification
The bench builds the slave with its default 8-bit pointer, which gives a 256-entry register file. At that size the wrap from 0xFF to 0x00 is reached in a three-byte stream. The serial clock runs at one sixteenth of the system clock, which leaves several system cycles between each synchronized edge and the point where the bench samples. Both pin modes are exercised against the same register contents, so data written in one mode is read back in the other.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  CMD_SETPTR = 8'h7D,
  parameter logic [7:0]  CMD_WRITE  = 8'h7E,
  parameter logic [7:0]  CMD_READ   = 8'h7F
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_shared,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  input  logic sio_in,
  output logic sio_out,
  output logic sio_oe
);

  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {ST_CMD, ST_PTR, ST_WR, ST_RD, ST_IGN} state_t;

  logic [2:0]        sck_sy, cs_sy;
  logic [1:0]        mosi_sy, sio_sy;
  logic [2:0]        bitcnt;
  logic [6:0]        sh;
  logic [7:0]        tx;
  logic [ADDR_W-1:0] ptr;
  logic              oe_q;
  state_t            st;
  logic [7:0]        mem [DEPTH];

  wire active    = ~cs_sy[1];
  wire start     = cs_sy[2] & ~cs_sy[1];
  wire rise      = active & sck_sy[1] & ~sck_sy[2];
  wire fall      = active & ~sck_sy[1] & sck_sy[2];
  wire din       = cfg_shared ? sio_sy[1] : mosi_sy[1];
  wire [7:0] byte_in = {sh, din};
  wire byte_done = rise & (bitcnt == 3'd7);
  wire wr_en     = byte_done & (st == ST_WR);

  assign miso    = active & ~cfg_shared & tx[7];
  assign sio_out = tx[7];
  assign sio_oe  = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
      sio_sy  <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck};
      cs_sy   <= {cs_sy[1:0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
      sio_sy  <= {sio_sy[0], sio_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      oe_q   <= 1'b0;
      st     <= ST_CMD;
    end else if (!active) begin
      bitcnt <= '0;
      oe_q   <= 1'b0;
      st     <= ST_CMD;
    end else begin
      if (start) tx <= mem[ptr];
      if (rise) begin
        sh     <= byte_in[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          case (st)
            ST_CMD: begin
              if (byte_in == CMD_SETPTR)     st <= ST_PTR;
              else if (byte_in == CMD_WRITE) st <= ST_WR;
              else if (byte_in == CMD_READ)  st <= ST_RD;
              else                           st <= ST_IGN;
            end
            ST_PTR: begin
              ptr <= byte_in[ADDR_W-1:0];
              st  <= ST_CMD;
            end
            ST_WR, ST_RD: ptr <= ptr + 1'b1;
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (bitcnt == 3'd0) begin
          tx <= mem[ptr];
          if (st == ST_RD && cfg_shared) oe_q <= 1'b1;
        end else begin
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ptr] <= byte_in;
    end
  end

  p_idle_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(ptr));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == ST_WR || st == ST_RD) && ptr == '1) |=> ptr == '0);
  p_oe_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> cfg_shared);
  p_oe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(st) == ST_RD);
  p_ignore_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == ST_IGN) |=> st == ST_IGN);
  p_deselect_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bitcnt == 3'd0 && !oe_q && st == ST_CMD));

endmodule

// File: tb/test_spi_regfile_slave.sv
module test_spi_regfile_slave;
  logic clk = 1'b0;
  logic rst_n, cfg_shared, sck, cs_n, mosi, sio_in;
  logic miso, sio_out, sio_oe;
  int checks = 0, errors = 0;
  localparam int HALF = 8;

  always #10 clk = ~clk;

  spi_regfile_slave i_spi_regfile_slave (
    .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared), .sck(sck), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe));

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer_bits(input logic [7:0] d, input int nbits,
                           output logic [7:0] rx, output logic oe_seen, output logic miso_seen);
    rx = '0; oe_seen = 1'b0; miso_seen = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = d[i]; sio_in = d[i];
      wait_clk(HALF);
      rx[i] = cfg_shared ? sio_out : miso;
      oe_seen |= sio_oe;
      miso_seen |= miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] rx);
    logic o, m;
    xfer_bits(d, 8, rx, o, m);
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF); cs_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic t_reset();
    check(miso == 1'b0, "R1 reset miso", {7'd0, miso}, 8'h00);
    check(sio_oe == 1'b0, "R1 reset oe", {7'd0, sio_oe}, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] r;
    sel(); xb(8'h7D, r); xb(8'h10, r); xb(8'h7E, r);
    xb(8'hA5, r); xb(8'h3C, r); xb(8'h96, r); desel();
    sel(); xb(8'h7D, r); xb(8'h10, r); xb(8'h7F, r);
    xb(8'h00, r); check(r == 8'hA5, "R3 R4 R5 R2 read 0x10", r, 8'hA5);
    xb(8'h00, r); check(r == 8'h3C, "R5 stream 0x11", r, 8'h3C);
    desel();
  endtask

  task automatic t_cmd_echo();
    logic [7:0] r;
    sel(); xb(8'h7F, r);
    check(r == 8'h96, "R7 echo during command", r, 8'h96);
    xb(8'h00, r); check(r == 8'h96, "R5 first read byte at 0x12", r, 8'h96);
    desel();
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    sel(); xb(8'h7D, r); xb(8'hFE, r); xb(8'h7E, r);
    xb(8'h11, r); xb(8'h22, r); xb(8'h33, r); desel();
    sel(); xb(8'h7D, r); xb(8'h00, r); xb(8'h7F, r);
    xb(8'h00, r); check(r == 8'h33, "R6 write wrapped to 0x00", r, 8'h33);
    desel();
    sel(); xb(8'h7D, r); xb(8'hFE, r); xb(8'h7F, r);
    xb(8'h00, r); check(r == 8'h11, "R6 read 0xFE", r, 8'h11);
    xb(8'h00, r); check(r == 8'h22, "R6 read 0xFF", r, 8'h22);
    xb(8'h00, r); check(r == 8'h33, "R6 read wraps to 0x00", r, 8'h33);
    desel();
  endtask

  task automatic t_unknown();
    logic [7:0] r;
    sel(); xb(8'h7D, r); xb(8'h40, r); desel();
    sel(); xb(8'h55, r); xb(8'h7E, r); xb(8'h99, r); xb(8'h7D, r); xb(8'h00, r); desel();
    sel(); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'h00, "R9 nothing written, pointer kept", r, 8'h00);
    desel();
    sel(); xb(8'h7D, r); xb(8'h00, r); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'h33, "R9 register 0x00 untouched", r, 8'h33);
    desel();
  endtask

  task automatic t_abort();
    logic [7:0] r;
    logic o, m;
    sel(); xb(8'h7D, r); xb(8'h50, r); xb(8'h7E, r); xb(8'h77, r);
    xfer_bits(8'hAB, 4, r, o, m); desel();
    sel(); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'h00, "R10 partial byte dropped at 0x51", r, 8'h00);
    desel();
    sel(); xb(8'h7D, r); xb(8'h50, r); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'h77, "R10 full byte kept at 0x50", r, 8'h77);
    desel();
  endtask

  task automatic t_idle();
    logic [7:0] r;
    logic o, m;
    sel(); xb(8'h7D, r); xb(8'h30, r); xb(8'h7E, r); xb(8'hEE, r); desel();
    xfer_bits(8'h7D, 8, r, o, m); xfer_bits(8'h30, 8, r, o, m);
    xfer_bits(8'h7E, 8, r, o, m); xfer_bits(8'h00, 8, r, o, m);
    check(m == 1'b0, "R1 miso quiet while deselected", {7'd0, m}, 8'h00);
    sel(); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'h00, "R1 pointer still 0x31", r, 8'h00);
    desel();
    sel(); xb(8'h7D, r); xb(8'h30, r); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'hEE, "R1 register 0x30 kept", r, 8'hEE);
    desel();
  endtask

  task automatic t_shared();
    logic [7:0] r;
    logic o, m, oe_any, m_any;
    cfg_shared = 1'b1; wait_clk(4);
    oe_any = 1'b0; m_any = 1'b0;
    sel();
    xfer_bits(8'h7D, 8, r, o, m); oe_any |= o; m_any |= m;
    xfer_bits(8'h10, 8, r, o, m); oe_any |= o; m_any |= m;
    xfer_bits(8'h7F, 8, r, o, m); oe_any |= o; m_any |= m;
    check(oe_any == 1'b0, "R8 no drive during command", {7'd0, oe_any}, 8'h00);
    wait_clk(5);
    check(sio_oe == 1'b1, "R8 drive after read command", {7'd0, sio_oe}, 8'h01);
    xfer_bits(8'hFF, 8, r, o, m); m_any |= m;
    check(r == 8'hA5, "R8 shared read 0x10", r, 8'hA5);
    xfer_bits(8'hFF, 8, r, o, m); m_any |= m;
    check(r == 8'h3C, "R8 shared read 0x11", r, 8'h3C);
    check(sio_oe == 1'b1, "R8 drive held", {7'd0, sio_oe}, 8'h01);
    check(m_any == 1'b0, "R11 miso quiet in shared mode", {7'd0, m_any}, 8'h00);
    desel();
    check(sio_oe == 1'b0, "R8 drive released", {7'd0, sio_oe}, 8'h00);
    oe_any = 1'b0;
    sel();
    xfer_bits(8'h7D, 8, r, o, m); oe_any |= o;
    xfer_bits(8'h70, 8, r, o, m); oe_any |= o;
    xfer_bits(8'h7E, 8, r, o, m); oe_any |= o;
    xfer_bits(8'hC3, 8, r, o, m); oe_any |= o;
    desel();
    check(oe_any == 1'b0, "R8 no drive during write", {7'd0, oe_any}, 8'h00);
    cfg_shared = 1'b0; wait_clk(4);
    sel(); xb(8'h7D, r); xb(8'h70, r); xb(8'h7F, r); xb(8'h00, r);
    check(r == 8'hC3, "R11 shared write read back", r, 8'hC3);
    desel();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_shared = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0; sio_in = 1'b0;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    t_reset();
    t_write_read();
    t_cmd_echo();
    t_wrap();
    t_unknown();
    t_abort();
    t_idle();
    t_shared();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule